// File: doc/BRIEF.md
# BLAKE2b G Mixing Unit

This block carries out one application of the BLAKE2b mixing function on four 64-bit working words `a`, `b`, `c`, `d`, using two 64-bit message words `x` and `y`. It returns the four mixed words. The unit does not know which step of a round it is serving. The caller picks which four state words to present, so the same unit handles both column mixing and diagonal mixing.

The mixing runs as two half-steps with the same shape. Each half-step adds `b` and one message word into `a`. It folds the new `a` into `d` and rotates `d`. It adds `d` into `c`, then folds `c` into `b` and rotates `b`. The first half-step uses rotations of 32 and 24. The second uses 16 and 63, and works on the words the first half-step produced. Every rotation is fixed wiring.

The block does not select message words, sequence rounds, initialise state or apply the feed-forward. The caller does all of these. By default one output register follows the combinational datapath, and a valid flag travels beside the data. A parameter can remove the register and make the unit purely combinational.

Top module: `blake_g_mix`

## Requirements
- R1: The first update of `a` is `a + b + x`, truncated to 64 bits.
- R2: The first update of `d` is `(d XOR a')` rotated right by 32, where `a'` is the value from R1.
- R3: The first update of `c` is `c + d'`, and the first update of `b` is `(b XOR c')` rotated right by 24. Both use the values just computed.
- R4: The second half-step takes the words from R1 to R3 as its inputs. It computes `a'' = a' + b' + y`, then `d'' = (d' XOR a'')` rotated right by 16.
- R5: The final words are `c'' = c' + d''` and `b'' = (b' XOR c'')` rotated right by 63 (the same as rotating left by 1). The outputs are `a''`, `b''`, `c''`, `d''`.
- R6: Every sum is taken modulo 2^64, and any carry out of bit 63 is discarded.
- R7: In the registered build, `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R8: In the registered build, while `in_valid` is low, the output words keep their last computed values whatever the data inputs do.
- R9: Synchronous active-high `rst` clears `out_valid` and all four output words to zero.
- R10: With `in_valid` held high on consecutive cycles, every cycle delivers the result of the operands from the cycle before. No cycle is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| a_in | input | 64 | State word a |
| b_in | input | 64 | State word b |
| c_in | input | 64 | State word c |
| d_in | input | 64 | State word d |
| x_in | input | 64 | Message word for the first half-step |
| y_in | input | 64 | Message word for the second half-step |
| out_valid | output | 1 | Mixed words are valid |
| a_out | output | 64 | Mixed word a |
| b_out | output | 64 | Mixed word b |
| c_out | output | 64 | Mixed word c |
| d_out | output | 64 | Mixed word d |

## Verification
Two events can fall in the same clock edge: the output register loads a new result while the previous result is being presented with `out_valid` high. The bench provokes this by holding `in_valid` high on consecutive cycles, with a different operand set on each cycle. On each following cycle it checks that the outputs equal the result for the operands of the cycle just before, never a stale or mixed value. A separate gap test changes the operands while `in_valid` is low. It confirms that the held result and a low `out_valid` are not disturbed.

// File: rtl/blake_g_pkg.sv
package blake_g_pkg;

    localparam int WORD_W = 64;

    // Rotation amounts of the two half-steps
    localparam int ROT_D1 = 32;
    localparam int ROT_B1 = 24;
    localparam int ROT_D2 = 16;
    localparam int ROT_B2 = 63;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
    } quad_t;

    // Left rotation by a constant, used by checks to undo a right rotation
    function automatic word_t rotl_const(input word_t v, input int amt);
        word_t r;
        for (int i = 0; i < WORD_W; i++) begin
            r[(i + amt) % WORD_W] = v[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/g_rotr.sv
module g_rotr #(
    parameter int W   = 64,
    parameter int AMT = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // Fixed rotation: pure re-ordering of wires
    generate
        if (AMT == 0) begin : g_pass
            assign dout = din;
        end else begin : g_rot
            assign dout = {din[AMT-1:0], din[W-1:AMT]};
        end
    endgenerate
endmodule

// File: rtl/g_half_step.sv
module g_half_step
    import blake_g_pkg::*;
#(
    parameter int ROT_D = 32,
    parameter int ROT_B = 24
) (
    input  quad_t q_i,
    input  word_t m_i,
    output quad_t q_o
);
    word_t a_sum;
    word_t d_mix;
    word_t d_rot;
    word_t c_sum;
    word_t b_mix;
    word_t b_rot;

    // a takes b and the message word, modulo 2^64
    assign a_sum = q_i.a + q_i.b + m_i;
    assign d_mix = q_i.d ^ a_sum;

    g_rotr #(.W(WORD_W), .AMT(ROT_D)) u_rot_d (
        .din  (d_mix),
        .dout (d_rot)
    );

    assign c_sum = q_i.c + d_rot;
    assign b_mix = q_i.b ^ c_sum;

    g_rotr #(.W(WORD_W), .AMT(ROT_B)) u_rot_b (
        .din  (b_mix),
        .dout (b_rot)
    );

    always_comb begin
        q_o.a = a_sum;
        q_o.b = b_rot;
        q_o.c = c_sum;
        q_o.d = d_rot;
    end

    // Undoing each rotation must give back the XOR of old word and new partner (R2, R3, R4, R5)
    always_comb begin
        p_d_invert_r2: assert (((rotl_const(q_o.d, ROT_D) ^ q_o.a) == q_i.d))
            else $error("d rotation/xor mismatch");
        p_b_invert_r3: assert (((rotl_const(q_o.b, ROT_B) ^ q_o.c) == q_i.b))
            else $error("b rotation/xor mismatch");
        p_c_sum_r5: assert ((q_o.c - q_o.d) == q_i.c)
            else $error("c addition mismatch");
    end
endmodule

// File: rtl/blake_g_mix.sv
module blake_g_mix
    import blake_g_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    input  logic [WORD_W-1:0] c_in,
    input  logic [WORD_W-1:0] d_in,
    input  logic [WORD_W-1:0] x_in,
    input  logic [WORD_W-1:0] y_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] a_out,
    output logic [WORD_W-1:0] b_out,
    output logic [WORD_W-1:0] c_out,
    output logic [WORD_W-1:0] d_out
);
    quad_t q_in;
    quad_t q_mid;
    quad_t q_fin;

    always_comb begin
        q_in.a = a_in;
        q_in.b = b_in;
        q_in.c = c_in;
        q_in.d = d_in;
    end

    g_half_step #(.ROT_D(ROT_D1), .ROT_B(ROT_B1)) u_first (
        .q_i (q_in),
        .m_i (x_in),
        .q_o (q_mid)
    );

    g_half_step #(.ROT_D(ROT_D2), .ROT_B(ROT_B2)) u_second (
        .q_i (q_mid),
        .m_i (y_in),
        .q_o (q_fin)
    );

    generate
        if (REGISTERED) begin : g_reg
            quad_t q_hold;
            logic  vld_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    q_hold <= '0;
                    vld_q  <= 1'b0;
                end else begin
                    vld_q <= in_valid;
                    if (in_valid) begin
                        q_hold <= q_fin;
                    end
                end
            end

            assign out_valid = vld_q;
            assign a_out     = q_hold.a;
            assign b_out     = q_hold.b;
            assign c_out     = q_hold.c;
            assign d_out     = q_hold.d;

            p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            p_valid_drops_r7: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
            p_hold_a_r8: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> $stable(a_out));
            p_hold_bcd_r8: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> ($stable(b_out) && $stable(c_out) && $stable(d_out)));
            p_reset_clear_r9: assert property (@(posedge clk)
                rst |=> (!out_valid && a_out == '0 && d_out == '0));
        end else begin : g_comb
            assign out_valid = in_valid;
            assign a_out     = q_fin.a;
            assign b_out     = q_fin.b;
            assign c_out     = q_fin.c;
            assign d_out     = q_fin.d;
        end
    endgenerate
endmodule

// File: tb/blake_g_mix_tb.sv
module blake_g_mix_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] a_in, b_in, c_in, d_in, x_in, y_in;
    logic        out_valid;
    logic [63:0] a_out, b_out, c_out, d_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    blake_g_mix dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
        .x_in(x_in), .y_in(y_in),
        .out_valid(out_valid),
        .a_out(a_out), .b_out(b_out), .c_out(c_out), .d_out(d_out)
    );

    function automatic logic [63:0] rr(input logic [63:0] v, input int n);
        logic [127:0] t;
        t = {v, v} >> n;
        return t[63:0];
    endfunction

    // Bench model of the mixing, written from the requirements
    function automatic logic [255:0] model(input logic [63:0] a, b, c, d, x, y);
        a = a + b + x;  d = rr(d ^ a, 32);
        c = c + d;      b = rr(b ^ c, 24);
        a = a + b + y;  d = rr(d ^ a, 16);
        c = c + d;      b = rr(b ^ c, 63);
        return {a, b, c, d};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_words(input string req, input logic [255:0] exp);
        chk({req, " a"}, a_out, exp[255:192]);
        chk({req, " b"}, b_out, exp[191:128]);
        chk({req, " c"}, c_out, exp[127:64]);
        chk({req, " d"}, d_out, exp[63:0]);
    endtask

    task automatic drive(input logic [63:0] a, b, c, d, x, y);
        a_in = a; b_in = b; c_in = c; d_in = d; x_in = x; y_in = y;
    endtask

    // One operand set, one result, checked a cycle later
    task automatic run_one(input string req, input logic [63:0] a, b, c, d, x, y);
        @(negedge clk);
        drive(a, b, c, d, x, y);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
        chk_words(req, model(a, b, c, d, x, y));
    endtask

    task automatic t_reset();
        chk("R9 valid", {63'd0, out_valid}, 64'd0);
        chk_words("R9", 256'd0);
    endtask

    task automatic t_first_half();
        run_one("R1 zero", 0, 0, 0, 0, 0, 0);
        run_one("R1 x only", 0, 0, 0, 0, 64'h1, 0);
        run_one("R2 d only", 0, 0, 0, 64'h8000_0000_0000_0001, 0, 0);
        run_one("R3 b,c", 0, 64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, 0, 0, 0);
    endtask

    task automatic t_second_half();
        run_one("R4 y only", 0, 0, 0, 0, 0, 64'h0000_0001_0000_0000);
        run_one("R5 mixed", 64'h6a09e667f3bcc908, 64'h510e527fade682d1,
                64'h3c6ef372fe94f82b, 64'h1f83d9abfb41bd6b,
                64'h0706050403020100, 64'h0f0e0d0c0b0a0908);
        run_one("R5 pattern", 64'haaaa_5555_aaaa_5555, 64'h5555_aaaa_5555_aaaa,
                64'hdead_beef_cafe_f00d, 64'h0000_ffff_0000_ffff,
                64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321);
    endtask

    task automatic t_carry();
        run_one("R6 all ones", '1, '1, '1, '1, '1, '1);
        run_one("R6 top bits", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
                64'hffff_ffff_ffff_ffff, 64'h8000_0000_0000_0000,
                64'h8000_0000_0000_0000, 64'hffff_ffff_ffff_ffff);
    endtask

    task automatic t_hold();
        logic [255:0] exp;
        exp = model(64'h11, 64'h22, 64'h33, 64'h44, 64'h55, 64'h66);
        run_one("R8 load", 64'h11, 64'h22, 64'h33, 64'h44, 64'h55, 64'h66);
        for (int i = 0; i < 3; i++) begin
            drive(64'hffff_0000 + i, 64'h9 * i, '1, 64'h7 << i, '1, 64'h3);
            @(negedge clk);
            chk("R7 valid low", {63'd0, out_valid}, 64'd0);
            chk_words("R8 hold", exp);
        end
    endtask

    task automatic t_back_to_back();
        logic [63:0] s;
        logic [255:0] prev;
        @(negedge clk);
        s = 64'h0102_0304_0506_0708;
        drive(s, ~s, s ^ 64'h5a, s + 64'd3, s << 4, s >> 4);
        prev = model(s, ~s, s ^ 64'h5a, s + 64'd3, s << 4, s >> 4);
        in_valid = 1'b1;
        for (int i = 1; i < 5; i++) begin
            @(negedge clk);
            chk("R10 valid", {63'd0, out_valid}, 64'd1);
            chk_words("R10 stream", prev);
            s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
            drive(s, ~s, s ^ 64'h5a, s + 64'd3, s << 4, s >> 4);
            prev = model(s, ~s, s ^ 64'h5a, s + 64'd3, s << 4, s >> 4);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk_words("R10 last", prev);
        @(negedge clk);
        chk("R7 after stream", {63'd0, out_valid}, 64'd0);
        chk_words("R8 after stream", prev);
    endtask

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        drive('1, '1, '1, '1, '1, '1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_first_half();
        t_second_half();
        t_carry();
        t_hold();
        t_back_to_back();
        // reset after activity clears everything again
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        t_reset();
        rst = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule